// File: doc/BRIEF.md
# Calibrated Seconds Prescaler

This block turns a stream of single-cycle oscillator enables, nominally 32,768 per second, into a one-cycle seconds tick and a 512 Hz frequency-test square wave. It also applies a digital rate correction. In chosen seconds, one pass through the fine 256-count divider stage is either cut to half its length or dropped altogether. This lets software trim a crystal that runs slightly fast or slow.

A six-bit trim word sets the correction. Its top bit selects the direction, where 1 speeds the clock up and 0 slows it down. The five low bits give a magnitude N. The block keeps its own seconds-in-minute and minute-in-cycle counters, and the cycle is 64 minutes long. In each cycle, the first second of each of the first 2N minutes receives one correction. The last two minutes of the cycle are never corrected. The test output comes from its own divider and does not respond to the trim word. Two inputs act on the divider: a stop input freezes the whole block, and a divider-clear strobe restarts the sub-second chain.

Top module: `cal_prescaler`

## Requirements
- R1: After reset, `sec_tick` and `ft_out` are both 0.
- R2: With magnitude `cal[4:0]` equal to 0, every second lasts FINE_DIV*COARSE_DIV enabled oscillator ticks, whatever the value of the sign bit `cal[5]`.
- R3: With `cal[5]`=1 (speed up), a corrected second is FINE_DIV/2 ticks shorter than a nominal second.
- R4: With `cal[5]`=0 (slow down), a corrected second is FINE_DIV ticks longer than a nominal second.
- R5: Only second index 0 of a minute whose index within the cycle is below 2N is corrected. All other seconds are nominal, and the pattern repeats every MIN_PER_CYC minutes.
- R6: Minutes MIN_PER_CYC-2 and MIN_PER_CYC-1 of every cycle are never corrected, even for the largest magnitude.
- R7: `ft_out` toggles once every FINE_DIV/2^FT_SHIFT enabled ticks, for any trim word.
- R8: While `stop` is 1, no tick advances any counter. `sec_tick` stays 0 and `ft_out` holds its value. When `stop` returns to 0, counting resumes from the point where it halted.
- R9: A cycle with `div_rst`=1 clears the sub-second chain and the test output to 0, and drops any tick in that cycle. The next seconds tick arrives one full second of ticks later.
- R10: `sec_tick` is a registered pulse exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator enable |
| cal | input | CAL_W+1 | Trim word: [CAL_W] is the direction (1 = faster), [CAL_W-1:0] is the magnitude |
| stop | input | 1 | Halts all counting while 1 |
| div_rst | input | 1 | Clears the sub-second divider chain |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |
| ft_out | output | 1 | Frequency-test square wave |

## Verification
The bench times every interval between seconds ticks over more than one full correction cycle. It does this for a zero magnitude with both signs, a small positive magnitude, a small negative magnitude, and the full magnitude with both signs. A design that corrected every second of a minute, or that ignored the two-minute cap at the end of the cycle, would give a wrong interval at a known second. So would a design that swapped the shortening and lengthening amounts, or that let a negative zero trim act. Every half period of the test output is measured under the same trim words, so a test divider tapped after the corrected stage would shift by the correction. Stop and divider-clear are applied in the middle of a second, and the bench checks the exact arrival of the next tick.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_SHORT = 2'd1,
    CORR_LONG  = 2'd2
  } corr_kind_e;
endpackage

// File: rtl/cps_window.sv
module cps_window
  import cps_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int CAL_W       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_evt,
  input  logic [CAL_W:0]   cal,
  output corr_kind_e       corr
);
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MIN_W = (MIN_PER_CYC > 1) ? $clog2(MIN_PER_CYC) : 1;
  localparam int CMP_W = ((CAL_W + 1) > MIN_W) ? (CAL_W + 1) : MIN_W;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYC - 1);
  localparam logic [CMP_W-1:0] MIN_CAP  = CMP_W'(MIN_PER_CYC - 2);

  logic [SEC_W-1:0] sec_idx;
  logic [MIN_W-1:0] min_idx;
  logic [CMP_W-1:0] min_x;
  logic [CMP_W-1:0] span_x;
  logic             eligible;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_idx <= '0;
      min_idx <= '0;
    end else if (sec_evt) begin
      if (sec_idx == SEC_LAST) begin
        sec_idx <= '0;
        min_idx <= (min_idx == MIN_LAST) ? '0 : min_idx + 1'b1;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end

  // Twice the magnitude sets how many leading minutes are eligible.
  assign min_x    = CMP_W'(min_idx);
  assign span_x   = CMP_W'({cal[CAL_W-1:0], 1'b0});
  assign eligible = (sec_idx == '0) && (min_x < span_x) && (min_x < MIN_CAP);

  always_comb begin
    corr = CORR_NONE;
    if (eligible) corr = cal[CAL_W] ? CORR_SHORT : CORR_LONG;
  end
endmodule

// File: rtl/cps_fine_stage.sv
module cps_fine_stage
  import cps_pkg::*;
#(
  parameter int LO_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       clr,
  input  logic       sec_evt,
  input  corr_kind_e corr,
  output logic       lo_adv
);
  localparam logic [LO_W-1:0] LO_MAX   = {LO_W{1'b1}};
  localparam logic [LO_W-1:0] HALF_MAX = LO_W'((1 << (LO_W - 1)) - 1);

  logic [LO_W-1:0] lo_cnt;
  logic            done;
  logic            pend_short;
  logic            pend_long;
  logic            term;
  logic            wrap;

  assign pend_short = (corr == CORR_SHORT) && !done;
  assign pend_long  = (corr == CORR_LONG) && !done;
  assign term       = pend_short ? (lo_cnt == HALF_MAX) : (lo_cnt == LO_MAX);
  assign wrap       = en && term;
  // A lengthening correction blanks one stage output.
  assign lo_adv     = wrap && !pend_long;

  always_ff @(posedge clk) begin
    if (rst || clr) lo_cnt <= '0;
    else if (en)    lo_cnt <= wrap ? '0 : lo_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                       done <= 1'b0;
    else if (sec_evt)                     done <= 1'b0;
    else if (wrap && (pend_short || pend_long)) done <= 1'b1;
  end
endmodule

// File: rtl/cps_coarse_stage.sv
module cps_coarse_stage #(
  parameter int HI_DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic lo_adv,
  output logic sec_evt
);
  localparam int HI_W = (HI_DIV > 1) ? $clog2(HI_DIV) : 1;
  localparam logic [HI_W-1:0] HI_LAST = HI_W'(HI_DIV - 1);

  logic [HI_W-1:0] hi_cnt;

  assign sec_evt = lo_adv && (hi_cnt == HI_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) hi_cnt <= '0;
    else if (lo_adv) hi_cnt <= sec_evt ? '0 : hi_cnt + 1'b1;
  end
endmodule

// File: rtl/cps_ft_gen.sv
module cps_ft_gen #(
  parameter int FT_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic ft_out
);
  logic [FT_W-1:0] ft_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ft_cnt <= '0;
      ft_out <= 1'b0;
    end else if (en) begin
      ft_cnt <= ft_cnt + 1'b1;
      if (ft_cnt == {FT_W{1'b1}}) ft_out <= ~ft_out;
    end
  end
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cps_pkg::*;
#(
  parameter int LO_W        = 8,
  parameter int HI_DIV      = 128,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int CAL_W       = 5,
  parameter int FT_SHIFT    = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           osc_tick,
  input  logic [CAL_W:0] cal,
  input  logic           stop,
  input  logic           div_rst,
  output logic           sec_tick,
  output logic           ft_out
);
  localparam int FT_W = LO_W - FT_SHIFT;

  logic       en_core;
  logic       lo_adv;
  logic       sec_evt;
  corr_kind_e corr;

  assign en_core = osc_tick && !stop && !div_rst;

  cps_window #(
    .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYC(MIN_PER_CYC), .CAL_W(CAL_W)
  ) u_window (
    .clk(clk), .rst(rst), .sec_evt(sec_evt), .cal(cal), .corr(corr)
  );

  cps_fine_stage #(.LO_W(LO_W)) u_fine (
    .clk(clk), .rst(rst), .en(en_core), .clr(div_rst),
    .sec_evt(sec_evt), .corr(corr), .lo_adv(lo_adv)
  );

  cps_coarse_stage #(.HI_DIV(HI_DIV)) u_coarse (
    .clk(clk), .rst(rst), .clr(div_rst), .lo_adv(lo_adv), .sec_evt(sec_evt)
  );

  cps_ft_gen #(.FT_W(FT_W)) u_ft (
    .clk(clk), .rst(rst), .en(en_core), .clr(div_rst), .ft_out(ft_out)
  );

  always_ff @(posedge clk) begin
    if (rst) sec_tick <= 1'b0;
    else     sec_tick <= sec_evt;
  end
endmodule

// File: rtl/cal_prescaler_chk.sv
module cal_prescaler_chk (
  input logic clk,
  input logic rst,
  input logic osc_tick,
  input logic stop,
  input logic div_rst,
  input logic sec_tick,
  input logic ft_out
);
  a_r10_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);

  a_r8_stop_no_tick: assert property (@(posedge clk) disable iff (rst)
    stop |=> !sec_tick);

  a_r8_stop_ft_hold: assert property (@(posedge clk) disable iff (rst)
    (stop && !div_rst) |=> $stable(ft_out));

  a_r9_clear_outputs: assert property (@(posedge clk) disable iff (rst)
    div_rst |=> (!sec_tick && !ft_out));

  a_r7_ft_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (!osc_tick && !div_rst) |=> $stable(ft_out));
endmodule

bind cal_prescaler cal_prescaler_chk u_chk (
  .clk(clk), .rst(rst), .osc_tick(osc_tick), .stop(stop),
  .div_rst(div_rst), .sec_tick(sec_tick), .ft_out(ft_out)
);

// File: tb/sim_cal_prescaler.sv
`timescale 1ns/1ps
module sim_cal_prescaler;
  localparam int LO_W = 4;
  localparam int HI_DIV = 8;
  localparam int SPM = 4;
  localparam int MPC = 8;
  localparam int NOM = (1 << LO_W) * HI_DIV;
  localparam int FT_HALF = (1 << LO_W) >> 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic [5:0] cal = '0;
  logic       stop = 1'b0;
  logic       div_rst = 1'b0;
  logic       sec_tick;
  logic       ft_out;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cal_prescaler #(
    .LO_W(LO_W), .HI_DIV(HI_DIV), .SEC_PER_MIN(SPM), .MIN_PER_CYC(MPC),
    .CAL_W(5), .FT_SHIFT(3)
  ) u0 (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cal(cal), .stop(stop),
    .div_rst(div_rst), .sec_tick(sec_tick), .ft_out(ft_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int k, input logic [5:0] c);
    int s = k % SPM;
    int m = (k / SPM) % MPC;
    int n = int'(c[4:0]);
    if (s == 0 && m < 2 * n && m < MPC - 2) return c[5] ? NOM - (1 << (LO_W - 1)) : NOM + (1 << LO_W);
    return NOM;
  endfunction

  task automatic do_reset(input logic [5:0] c);
    @(negedge clk);
    rst = 1'b1; osc_tick = 1'b0; stop = 1'b0; div_rst = 1'b0; cal = c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_sec();
    do @(negedge clk); while (!sec_tick);
  endtask

  // R1: idle outputs after reset
  task automatic t_reset();
    do_reset(6'd0);
    repeat (3) @(negedge clk);
    check("R1 sec_tick", int'(sec_tick), 0);
    check("R1 ft_out", int'(ft_out), 0);
  endtask

  // R2..R7, R10: interval of every second and every test half period
  task automatic t_run(input logic [5:0] c, input string req, input int nsec);
    int k = -1;
    int last = 0;
    int last_ft = -1;
    logic prev_sec = 1'b0;
    logic prev_ft = 1'b0;
    do_reset(c);
    osc_tick = 1'b1;
    while (k < nsec) begin
      @(negedge clk);
      if (ft_out != prev_ft) begin
        if (last_ft >= 0) check("R7 ft half period", cyc - last_ft, FT_HALF);
        last_ft = cyc;
      end
      prev_ft = ft_out;
      if (sec_tick && prev_sec) check("R10 pulse width", 2, 1);
      if (sec_tick && !prev_sec) begin
        k++;
        if (k >= 1) check(req, cyc - last, exp_len(k, c));
        last = cyc;
      end
      prev_sec = sec_tick;
    end
    osc_tick = 1'b0;
  endtask

  // R8: stop in the middle of a second
  task automatic t_stop();
    int c0;
    int bad = 0;
    logic f0;
    do_reset(6'd0);
    osc_tick = 1'b1;
    wait_sec();
    c0 = cyc;
    repeat (50) @(negedge clk);
    stop = 1'b1;
    f0 = ft_out;
    repeat (37) begin
      @(negedge clk);
      if (sec_tick) bad++;
      if (ft_out != f0) bad++;
    end
    stop = 1'b0;
    check("R8 frozen during stop", bad, 0);
    wait_sec();
    check("R8 resumed second length", cyc - c0, NOM + 37);
    osc_tick = 1'b0;
  endtask

  // R9: divider clear in the middle of a second
  task automatic t_divrst();
    int d;
    do_reset(6'd0);
    osc_tick = 1'b1;
    wait_sec();
    repeat (61) @(negedge clk);
    div_rst = 1'b1;
    @(negedge clk);
    div_rst = 1'b0;
    d = cyc;
    check("R9 ft cleared", int'(ft_out), 0);
    wait_sec();
    check("R9 full second after clear", cyc - d, NOM);
    osc_tick = 1'b0;
  endtask

  initial begin
    t_reset();
    t_run(6'b000000, "R2 zero trim", 40);
    t_run(6'b100000, "R2 zero trim sign set", 40);
    t_run(6'b100001, "R3 R5 fast N=1", 40);
    t_run(6'b000011, "R4 R5 slow N=3", 40);
    t_run(6'b011111, "R6 slow N=31", 40);
    t_run(6'b111111, "R6 fast N=31", 40);
    t_stop();
    t_divrst();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule